// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block connects a clocked host to an external asynchronous static RAM of 128K words by 16 bits. The host offers one word per request over a valid/ready handshake. Each request carries a 17-bit word address, a write flag, write data and two active-low byte-lane enables. The controller then runs one properly timed read or write cycle on the memory pins. Read results come back on a data bus with a one-clock valid pulse.

Every minimum timing figure of the memory is given as a parameter in nanoseconds, along with the clock period. At elaboration each figure becomes a whole number of clock cycles, rounded up. Writes are strobed by the write enable. The controller waits until the memory has surely released the shared bus before it drives data. It holds that data for the whole data setup window and releases it one cycle after the strobe rises. Between accesses the chip is kept deselected, which puts it in its low-power standby state.

A retention input holds the memory in standby while its supply is lowered. After retention ends, or after reset, the controller waits one full read cycle time before it accepts the next access.

Top module: `sram_ctl`

## Requirements
- R1: Whenever no access is in progress, the memory pins sit in standby: mem_cs1_n=1, mem_cs2=0, mem_we_n=1, mem_oe_n=1, mem_be_n=2'b11 and mem_dq_oe=0. During an access, mem_cs1_n=0 and mem_cs2=1. The two chip selects always have opposite levels.
- R2: A read holds address, selects, lanes and mem_oe_n=0 for N_RC=ceil(T_RC_NS/CLK_NS) cycles. It samples mem_dq_in at the end of the last of those cycles. rd_valid pulses for one clock, N_RC+1 cycles after the cycle in which the request was accepted.
- R3: mem_be_n[0] and req_be_n[0] control bits 7:0, and bit 1 of each controls bits 15:8 (0 = lane enabled). On a read, the rd_data lane of any disabled lane is zero.
- R4: A write holds mem_we_n low for N_WLOW = max(ceil(T_WP_NS/CLK_NS), ceil(T_AW_NS/CLK_NS), N_DRV+ceil(T_DW_NS/CLK_NS)) cycles. Address, selects and lanes stay stable from the first low cycle onward.
- R5: mem_dq_oe rises only after mem_we_n has been low for N_DRV=ceil(max(T_WHZ_NS,T_HZ_NS)/CLK_NS) cycles. The driven data is stable for at least ceil(T_DW_NS/CLK_NS) cycles before mem_we_n rises. mem_dq_oe stays high in the cycle in which mem_we_n rises and falls in the cycle after it.
- R6: A write changes only the enabled byte lanes of the addressed word.
- R7: Two consecutive accesses begin at least ceil(max(T_RC_NS,T_WC_NS)/CLK_NS) cycles apart.
- R8: A request with req_be_n=2'b11 is a no-operation. It is accepted, and the chip stays deselected. For a read, rd_valid pulses in the cycle after acceptance with rd_data=0.
- R9: While retain is high, req_ready is low and the pins stay in standby, so requests are ignored. After retain is sampled low, and after reset, req_ready returns only after N_RC cycles of recovery: N_RC+1 cycles after the deassertion cycle.
- R10: req_ready is high only in the idle state with retain low, and drops after each accepted access. mem_oe_n and mem_we_n are never low together. The controller never drives the bus while the memory may still be driving it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retain | input | 1 | Hold the memory in retention standby |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be_n | input | 2 | Active-low byte-lane enables |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 16 | Read result, disabled lanes zero |
| mem_addr | output | 17 | Memory address bus |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_be_n | output | 2 | Active-low byte-lane enables |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The assertions check the pin rules on every cycle. Standby pins whenever the controller is ready, opposite chip-select levels, and output enable never low together with write enable are all covered there. So are stable address and lanes during a selected access, the minimum strobe width, and drive confined to the strobe and its one-cycle tail. Only the bench scenarios can show the rest. Its memory model returns garbage until the access time has elapsed, commits only enabled lanes, and tracks how long the memory may keep driving the bus. Against that model the bench checks data values, lane masking, no-operation handling, read latency, access spacing and retention recovery.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_RECOV,
      ST_RETAIN,
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_WEND
   } phase_e;

   // whole clock cycles covering a time in ns
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
   import sram_ctl_pkg::*;
#(
   parameter int unsigned N_RC   = 12,
   parameter int unsigned N_WLOW = 11,
   parameter int unsigned N_WEND = 1,
   parameter int unsigned N_DRV  = 5,
   parameter int unsigned CW     = 4
)(
   input  logic clk,
   input  logic rst_n,
   input  logic retain,
   input  logic req_valid,
   input  logic req_write,
   input  logic req_noop,
   output logic req_ready,
   output logic accept,
   output logic cap,
   output logic sel_d,
   output logic sel_q,
   output logic rd_q,
   output logic wr_q,
   output logic drv_q
);

   phase_e        ph_q, ph_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          rd_d, wr_d, drv_d;

   assign req_ready = (ph_q == ST_IDLE) && !retain;
   assign accept    = req_ready && req_valid;
   assign cap       = (ph_q == ST_READ) && (cnt_q == CW'(N_RC - 1));

   always_comb begin
      ph_d  = ph_q;
      cnt_d = cnt_q + CW'(1);
      unique case (ph_q)
         ST_RECOV: begin
            if (retain) begin
               ph_d  = ST_RETAIN;
               cnt_d = '0;
            end else if (cnt_q == CW'(N_RC - 1)) begin
               ph_d  = ST_IDLE;
               cnt_d = '0;
            end
         end
         ST_RETAIN: begin
            cnt_d = '0;
            if (!retain) ph_d = ST_RECOV;
         end
         ST_IDLE: begin
            cnt_d = '0;
            if (retain)                     ph_d = ST_RETAIN;
            else if (req_valid && !req_noop) ph_d = req_write ? ST_WRITE : ST_READ;
         end
         ST_READ: begin
            if (cnt_q == CW'(N_RC - 1)) begin
               ph_d  = ST_IDLE;
               cnt_d = '0;
            end
         end
         ST_WRITE: begin
            if (cnt_q == CW'(N_WLOW - 1)) begin
               ph_d  = ST_WEND;
               cnt_d = '0;
            end
         end
         ST_WEND: begin
            if (cnt_q == CW'(N_WEND - 1)) begin
               ph_d  = ST_IDLE;
               cnt_d = '0;
            end
         end
         default: begin
            ph_d  = ST_IDLE;
            cnt_d = '0;
         end
      endcase
   end

   // pin levels decoded from the next phase, then registered
   always_comb begin
      sel_d = (ph_d == ST_READ) || (ph_d == ST_WRITE);
      rd_d  = (ph_d == ST_READ);
      wr_d  = (ph_d == ST_WRITE);
      drv_d = ((ph_d == ST_WRITE) && (cnt_d >= CW'(N_DRV))) ||
              ((ph_d == ST_WEND)  && (cnt_d == '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= ST_RECOV;
         cnt_q <= '0;
         sel_q <= 1'b0;
         rd_q  <= 1'b0;
         wr_q  <= 1'b0;
         drv_q <= 1'b0;
      end else begin
         ph_q  <= ph_d;
         cnt_q <= cnt_d;
         sel_q <= sel_d;
         rd_q  <= rd_d;
         wr_q  <= wr_d;
         drv_q <= drv_d;
      end
   end

endmodule

// File: rtl/sram_ctl_data.sv
module sram_ctl_data #(
   parameter int unsigned AW    = 17,
   parameter int unsigned DW    = 16,
   parameter int unsigned LANES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             sel_d,
   input  logic             cap,
   input  logic             noop_rd,
   input  logic [AW-1:0]    req_addr,
   input  logic [DW-1:0]    req_wdata,
   input  logic [LANES-1:0] req_be_n,
   input  logic [DW-1:0]    mem_dq_in,
   output logic [AW-1:0]    mem_addr,
   output logic [LANES-1:0] mem_be_n,
   output logic [DW-1:0]    mem_dq_out,
   output logic             rd_valid,
   output logic [DW-1:0]    rd_data
);

   localparam int unsigned LW = DW / LANES;

   logic [AW-1:0]    addr_q;
   logic [DW-1:0]    wdata_q;
   logic [LANES-1:0] be_q;
   logic             rv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '1;
         rv_q    <= 1'b0;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be_n;
         end
         rv_q <= cap || noop_rd;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic          pin_be_q;
      logic [LW-1:0] rd_lane_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pin_be_q  <= 1'b1;
            rd_lane_q <= '0;
         end else begin
            pin_be_q <= sel_d ? (accept ? req_be_n[l] : be_q[l]) : 1'b1;
            if (cap)          rd_lane_q <= be_q[l] ? '0 : mem_dq_in[l*LW +: LW];
            else if (noop_rd) rd_lane_q <= '0;
         end
      end

      assign mem_be_n[l]          = pin_be_q;
      assign rd_data[l*LW +: LW]  = rd_lane_q;
   end

   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;
   assign rd_valid   = rv_q;

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 17,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned LANES    = 2,
   parameter int unsigned CLK_NS   = 10,
   parameter int unsigned T_RC_NS  = 120,
   parameter int unsigned T_WC_NS  = 120,
   parameter int unsigned T_WP_NS  = 85,
   parameter int unsigned T_AW_NS  = 100,
   parameter int unsigned T_DW_NS  = 60,
   parameter int unsigned T_WHZ_NS = 35,
   parameter int unsigned T_HZ_NS  = 45
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              retain,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be_n,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [LANES-1:0]  mem_be_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int unsigned N_RC   = ns_to_cyc(T_RC_NS, CLK_NS);
   localparam int unsigned N_WC   = ns_to_cyc(T_WC_NS, CLK_NS);
   localparam int unsigned N_WP   = ns_to_cyc(T_WP_NS, CLK_NS);
   localparam int unsigned N_AW   = ns_to_cyc(T_AW_NS, CLK_NS);
   localparam int unsigned N_DW   = ns_to_cyc(T_DW_NS, CLK_NS);
   localparam int unsigned N_DRV  = ns_to_cyc(umax(T_WHZ_NS, T_HZ_NS), CLK_NS);
   localparam int unsigned N_WLOW = umax(N_WP, umax(N_AW, N_DRV + N_DW));
   localparam int unsigned N_WEND = (N_WC > N_WLOW + 1) ? (N_WC - N_WLOW) : 1;
   localparam int unsigned N_MAX  = umax(N_RC, umax(N_WLOW, N_WEND));
   localparam int unsigned CW     = $clog2(N_MAX + 1);

   if (CLK_NS == 0) begin : g_bad_clk
      $error("sram_ctl: CLK_NS must be non-zero");
   end
   if ((LANES == 0) || (DATA_W % LANES != 0)) begin : g_bad_lanes
      $error("sram_ctl: DATA_W must split evenly into LANES");
   end
   if (N_RC < 2) begin : g_bad_rc
      $error("sram_ctl: read cycle must span at least two clocks");
   end

   logic noop, accept, cap, sel_d, sel_q, rd_q, wr_q, drv_q;

   assign noop = &req_be_n;

   sram_ctl_seq #(
      .N_RC  (N_RC),
      .N_WLOW(N_WLOW),
      .N_WEND(N_WEND),
      .N_DRV (N_DRV),
      .CW    (CW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .retain   (retain),
      .req_valid(req_valid),
      .req_write(req_write),
      .req_noop (noop),
      .req_ready(req_ready),
      .accept   (accept),
      .cap      (cap),
      .sel_d    (sel_d),
      .sel_q    (sel_q),
      .rd_q     (rd_q),
      .wr_q     (wr_q),
      .drv_q    (drv_q)
   );

   sram_ctl_data #(
      .AW   (ADDR_W),
      .DW   (DATA_W),
      .LANES(LANES)
   ) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .sel_d     (sel_d),
      .cap       (cap),
      .noop_rd   (accept && noop && !req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_be_n  (req_be_n),
      .mem_dq_in (mem_dq_in),
      .mem_addr  (mem_addr),
      .mem_be_n  (mem_be_n),
      .mem_dq_out(mem_dq_out),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   assign mem_cs1_n = ~sel_q;
   assign mem_cs2   = sel_q;
   assign mem_oe_n  = ~rd_q;
   assign mem_we_n  = ~wr_q;
   assign mem_dq_oe = drv_q;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk
   import sram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W  = 17,
   parameter int unsigned LANES   = 2,
   parameter int unsigned CLK_NS  = 10,
   parameter int unsigned T_WP_NS = 85
)(
   input logic              clk,
   input logic              rst_n,
   input logic              retain,
   input logic              req_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs1_n,
   input logic              mem_cs2,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [LANES-1:0]  mem_be_n,
   input logic              mem_dq_oe
);

   localparam int unsigned MIN_WP = ns_to_cyc(T_WP_NS, CLK_NS);

   logic [15:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         low_cnt <= '0;
      else if (!mem_we_n) low_cnt <= low_cnt + 16'd1;
      else                low_cnt <= '0;
   end

   p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n &&
                     (mem_be_n == '1) && !mem_dq_oe));

   p_cs_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs1_n != mem_cs2);

   p_hold_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs1_n && $past(!mem_cs1_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

   p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (low_cnt >= 16'(MIN_WP)));

   p_drive_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n || $past(!mem_we_n)));

   p_drive_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && mem_we_n) |=> !mem_dq_oe);

   p_retain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      retain |-> !req_ready);

   p_rw_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n && !mem_oe_n));

   p_no_drive_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe);

endmodule

bind sram_ctl sram_ctl_chk #(
   .ADDR_W (ADDR_W),
   .LANES  (LANES),
   .CLK_NS (CLK_NS),
   .T_WP_NS(T_WP_NS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .retain   (retain),
   .req_ready(req_ready),
   .mem_addr (mem_addr),
   .mem_cs1_n(mem_cs1_n),
   .mem_cs2  (mem_cs2),
   .mem_we_n (mem_we_n),
   .mem_oe_n (mem_oe_n),
   .mem_be_n (mem_be_n),
   .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;

   localparam int CLK    = 5;
   localparam int E_RC   = (120 + CLK - 1) / CLK;   // 24
   localparam int E_WP   = (85 + CLK - 1) / CLK;    // 17
   localparam int E_AW   = (100 + CLK - 1) / CLK;   // 20
   localparam int E_DW   = (60 + CLK - 1) / CLK;    // 12
   localparam int E_HZ   = (45 + CLK - 1) / CLK;    // 9

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        retain = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be_n = 2'b11;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic [16:0] mem_addr;
   logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [1:0]  mem_be_n;
   logic [15:0] mem_dq_out;
   logic [15:0] mem_dq_in = 16'hBAD0;

   always #2.5 clk = ~clk;

   sram_ctl #(.CLK_NS(CLK)) dut (
      .clk(clk), .rst_n(rst_n), .retain(retain),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be_n(req_be_n),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] dflt(input logic [16:0] a);
      return a[15:0] ^ 16'h3C5A ^ {a[16], 15'd0};
   endfunction

   // ---------------- memory model ----------------
   logic [15:0] mem_arr [int];
   logic [15:0] ref_arr [int];
   logic [21:0] sig, psig = '0;
   int  acc_cnt = 0, hz_cnt = 0, wl = 0, dstab = 0, last_acc = 0;
   int  last_start = -1, sel_cnt = 0;
   bit  psel = 0, pwe_low = 0, rel_chk = 0, last_drv = 0;
   logic [16:0] last_addr;
   logic [1:0]  last_be;
   logic [15:0] last_dq, pdq;

   always @(negedge clk) begin
      if (rst_n) begin
         bit sel, reading;
         logic [15:0] cur;
         sel     = (mem_cs1_n === 1'b0) && (mem_cs2 === 1'b1);
         reading = sel && !mem_oe_n && mem_we_n && (mem_be_n != 2'b11);
         sig     = {mem_addr, mem_be_n, sel, mem_oe_n, mem_we_n};
         acc_cnt = (sig == psig) ? acc_cnt + 1 : 1;
         psig    = sig;
         if (sel) sel_cnt++;
         if (sel && !psel) begin
            if (last_start >= 0)
               check(cyc - last_start >= E_RC, "R7", "access spacing", cyc - last_start, E_RC);
            last_start = cyc;
         end
         psel = sel;
         // contention: memory may still drive the bus
         if (mem_dq_oe === 1'b1 && (reading || hz_cnt > 0))
            check(0, "R10", "drive during memory output window", hz_cnt, 0);
         hz_cnt = reading ? E_HZ + 1 : ((hz_cnt > 0) ? hz_cnt - 1 : 0);
         // read data appears only after the access time
         mem_dq_in = 16'hBAD0;
         if (reading && acc_cnt >= E_RC) begin
            cur = mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : dflt(mem_addr);
            if (!mem_be_n[0]) mem_dq_in[7:0]  = cur[7:0];
            if (!mem_be_n[1]) mem_dq_in[15:8] = cur[15:8];
         end
         // write strobe
         if (sel && !mem_we_n) begin
            wl++;
            if (mem_dq_oe) dstab = (last_drv && mem_dq_out == pdq) ? dstab + 1 : 1;
            else           dstab = 0;
            last_drv  = mem_dq_oe;
            pdq       = mem_dq_out;
            last_addr = mem_addr;
            last_be   = mem_be_n;
            last_dq   = mem_dq_out;
            last_acc  = acc_cnt;
            pwe_low   = 1;
         end else if (pwe_low) begin
            check(wl >= E_WP, "R4", "write strobe cycles", wl, E_WP);
            check(last_acc >= E_AW, "R4", "address/lanes stable before strobe end", last_acc, E_AW);
            check(dstab >= E_DW, "R5", "data setup cycles", dstab, E_DW);
            check(mem_dq_oe === 1'b1, "R5", "drive held in strobe-rise cycle", mem_dq_oe, 1);
            cur = mem_arr.exists(int'(last_addr)) ? mem_arr[int'(last_addr)] : dflt(last_addr);
            if (!last_be[0]) cur[7:0]  = last_dq[7:0];
            if (!last_be[1]) cur[15:8] = last_dq[15:8];
            mem_arr[int'(last_addr)] = cur;
            wl = 0; dstab = 0; last_drv = 0; pwe_low = 0; rel_chk = 1;
         end else if (rel_chk) begin
            check(mem_dq_oe === 1'b0, "R5", "drive released one cycle after strobe", mem_dq_oe, 0);
            rel_chk = 0;
         end
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [15:0] d;
      int          c;
      int          lat;
      string       tag;
   } exp_t;
   exp_t expq [$];

   always @(negedge clk) begin
      if (rst_n && rd_valid === 1'b1) begin
         if (expq.size() == 0) begin
            check(0, "R2", "unexpected rd_valid", 1, 0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            check(rd_data === e.d, e.tag, "read data", rd_data, e.d);
            check(cyc - e.c == e.lat, e.tag, "read latency", cyc - e.c, e.lat);
         end
      end
   end

   task automatic do_req(input bit wr, input logic [16:0] a, input logic [15:0] d,
                         input logic [1:0] be, input string tag);
      exp_t e;
      logic [15:0] cur;
      int acc;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be_n = be;
      while (!req_ready) @(negedge clk);
      acc = cyc;
      cur = ref_arr.exists(int'(a)) ? ref_arr[int'(a)] : dflt(a);
      if (wr) begin
         if (!be[0]) cur[7:0]  = d[7:0];
         if (!be[1]) cur[15:8] = d[15:8];
         ref_arr[int'(a)] = cur;
      end else begin
         e.d   = {be[1] ? 8'h00 : cur[15:8], be[0] ? 8'h00 : cur[7:0]};
         e.c   = acc;
         e.lat = (be == 2'b11) ? 1 : E_RC + 1;
         e.tag = tag;
         expq.push_back(e);
      end
      @(negedge clk);
      req_valid = 0;
      if (be != 2'b11) check(req_ready == 1'b0, "R10", "ready low after accept", req_ready, 0);
   endtask

   task automatic settle();
      while (!req_ready || expq.size() != 0 || pwe_low || rel_chk) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic check_standby(input string tag);
      check({mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe} === 7'b1011110,
            tag, "standby pins", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe},
            7'b1011110);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int c0, s0;
      repeat (4) @(negedge clk);
      check_standby("R1");
      check(req_ready == 1'b0, "R9", "ready low in reset", req_ready, 0);
      rst_n = 1;
      c0 = cyc;
      while (!req_ready) @(negedge clk);
      check(cyc - c0 >= E_RC, "R9", "recovery after reset", cyc - c0, E_RC);
      check_standby("R1");

      do_req(1, 17'h00010, 16'h1234, 2'b00, "R6");
      do_req(0, 17'h00010, 16'h0000, 2'b00, "R2");
      do_req(0, 17'h1FFFF, 16'h0000, 2'b00, "R2");
      settle();
      check_standby("R1");

      do_req(1, 17'h00010, 16'hABCD, 2'b10, "R6");   // lower lane only
      do_req(0, 17'h00010, 16'h0000, 2'b00, "R6");   // 12CD
      do_req(1, 17'h00010, 16'h5678, 2'b01, "R6");   // upper lane only
      do_req(0, 17'h00010, 16'h0000, 2'b00, "R6");   // 56CD
      do_req(0, 17'h00010, 16'h0000, 2'b10, "R3");   // 00CD
      do_req(0, 17'h00010, 16'h0000, 2'b01, "R3");   // 5600
      settle();

      // no-operation write and read
      s0 = sel_cnt;
      do_req(1, 17'h00010, 16'hFFFF, 2'b11, "R8");
      do_req(0, 17'h00010, 16'h0000, 2'b11, "R8");
      settle();
      check(sel_cnt == s0, "R8", "no select during no-op", sel_cnt - s0, 0);
      do_req(0, 17'h00010, 16'h0000, 2'b00, "R8");   // still 56CD
      settle();

      // retention: requests ignored, recovery wait
      @(negedge clk);
      retain = 1;
      s0 = sel_cnt;
      req_valid = 1; req_write = 1; req_addr = 17'h00010; req_wdata = 16'h0000; req_be_n = 2'b00;
      repeat (6) @(negedge clk);
      check(req_ready == 1'b0, "R9", "ready low in retention", req_ready, 0);
      check_standby("R9");
      req_valid = 0;
      @(negedge clk);
      check(sel_cnt == s0, "R9", "no access during retention", sel_cnt - s0, 0);
      retain = 0;
      c0 = cyc;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      check(cyc - c0 == E_RC + 1, "R9", "recovery after retention", cyc - c0, E_RC + 1);
      do_req(0, 17'h00010, 16'h0000, 2'b00, "R9");   // unchanged 56CD

      // mixed traffic over several addresses, including the ends
      for (int i = 0; i < 6; i++) begin
         logic [16:0] a;
         a = (i == 0) ? 17'h00000 : (i == 5) ? 17'h1FFFF : 17'(i * 17'h5A31);
         do_req(1, a, 16'(16'h9E37 * (i + 1)), 2'b00, "R6");
      end
      for (int i = 0; i < 6; i++) begin
         logic [16:0] a;
         a = (i == 0) ? 17'h00000 : (i == 5) ? 17'h1FFFF : 17'(i * 17'h5A31);
         do_req(0, a, 16'h0000, 2'b00, "R2");
      end
      do_req(1, 17'h00003, 16'hC3A5, 2'b00, "R7");
      do_req(1, 17'h00003, 16'h0F0F, 2'b01, "R7");
      do_req(0, 17'h00003, 16'h0000, 2'b00, "R7");
      settle();
      check_standby("R1");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule